// File: doc/BRIEF.md
# Oscilloscope and Logic-Analyser Trigger Unit

This unit sits beside the sampling path of a mixed-signal capture instrument. On every sample strobe it receives one 10-bit analog sample and one 8-bit digital sample. From these it decides whether a trigger event has happened. It has four trigger kinds:

- an analog threshold crossing on a chosen edge;
- an analog pulse that is shorter than a width limit;
- an analog pulse that is at least as long as a width limit;
- a masked pattern on the digital byte.

Software arms the unit with a one-cycle request. A force input lets software trigger an armed unit without waiting for a condition. After a trigger the unit waits for a fixed number of post-trigger samples and then reports that capture data is ready. A programmable holdoff, counted in samples from the trigger event, delays any new arming request.

All configuration arrives as byte-wide register values that the surrounding logic holds stable. The unit reports a 4-bit status code and gives a one-cycle pulse on each trigger event.

Top module: `scope_trig_unit`

## Requirements
- R1: The threshold is the 10-bit value {trig_cfg[1:0], thr_lo}. A valid analog sample counts as "above" when it is greater than or equal to the threshold.
- R2: In level mode, trig_cfg[2]=0 selects the rising edge (previous valid sample below, current sample above) and trig_cfg[2]=1 selects the falling edge. The first valid sample after reset never counts as an edge.
- R3: trig_cfg[6:5] selects the trigger kind: 00 level, 01 short pulse, 10 long pulse, 11 digital pattern. Conditions of kinds that are not selected cause no trigger.
- R4: A pulse starts at the selected-edge crossing and ends at the opposite crossing. Its length is the number of valid samples on the active side. Short-pulse mode triggers on the sample that ends the pulse when the length is less than the limit.
- R5: Long-pulse mode triggers on the sample that ends the pulse when the length is greater than or equal to the limit. The limit is width_lim, except that values below 4 are treated as 4.
- R6: Pattern mode triggers on a valid sample when every bit i with pat_ign[i]=0 has dig_smp[i]=pat_val[i]. Bits with pat_ign[i]=1 are ignored.
- R7: status reads 0x1 when idle, 0x4 when armed or post-counting with adc_en=1, 0x3 in those same states with adc_en=0, and 0x6 when data is ready.
- R8: An arm pulse in the idle or ready state arms the unit. trig_evt is high for exactly one cycle, in the cycle after the edge at which an armed unit accepts a trigger, and never in any other state.
- R9: force_trig on an armed unit triggers it at that clock edge. When the unit is not armed, force_trig has no effect.
- R10: After a trigger the unit counts POST_SMP further valid samples, 4 by default, and then reports 0x6. A force and a condition that arrive together give one event and one post window.
- R11: The holdoff {hold_hi, hold_lo} is loaded at each trigger and decreases by one per valid sample. An arm request made while it is nonzero is held, and it takes effect on the first edge at which the holdoff is zero.
- R12: Cycles with smp_valid=0 do not trigger, do not advance the pulse or edge history, and do not advance the post-trigger count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| ana_smp | input | 10 | Analog sample |
| dig_smp | input | 8 | Digital sample |
| thr_lo | input | 8 | Threshold low byte |
| trig_cfg | input | 8 | [1:0] threshold top bits, [2] falling edge, [6:5] trigger kind |
| pat_val | input | 8 | Digital pattern value |
| pat_ign | input | 8 | Pattern ignore mask (1 = ignored) |
| hold_lo | input | 8 | Holdoff low byte |
| hold_hi | input | 8 | Holdoff high byte |
| width_lim | input | 8 | Pulse width limit in samples |
| arm | input | 1 | Arm request pulse |
| adc_en | input | 1 | Converter enable, reflected in status |
| force_trig | input | 1 | Force a trigger while armed |
| trig_evt | output | 1 | One-cycle trigger event |
| status | output | 4 | Status code |

## Verification
Two things can reach an armed unit at the same clock edge: a force request and a real trigger condition. The bench raises force_trig in the same cycle as a matching digital pattern. It then judges the result by three outcomes: exactly one trig_evt pulse, status holding 0x4 for only one post window, and 0x6 appearing after exactly POST_SMP samples. The bench also makes an arm request fall inside a running holdoff and confirms that arming happens one cycle after the holdoff reaches zero.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int ANA_W     = 10;
    localparam int DIG_W     = 8;
    localparam int LIM_W     = 8;
    localparam int HOLD_W    = 16;
    localparam int MIN_PULSE = 4;

    typedef enum logic [1:0] {
        MODE_LEVEL   = 2'b00,
        MODE_SHORT   = 2'b01,
        MODE_LONG    = 2'b10,
        MODE_PATTERN = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_DONE
    } seq_state_e;

    localparam logic [3:0] STAT_IDLE      = 4'h1;
    localparam logic [3:0] STAT_ARM_ADC   = 4'h4;
    localparam logic [3:0] STAT_ARM_NOADC = 4'h3;
    localparam logic [3:0] STAT_READY     = 4'h6;
endpackage

// File: rtl/trig_detect.sv
module trig_detect
    import trig_pkg::*;
#(
    parameter int AW  = ANA_W,
    parameter int DW  = DIG_W,
    parameter int LW  = LIM_W,
    parameter int MINP = MIN_PULSE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [AW-1:0] ana_smp,
    input  logic [DW-1:0] dig_smp,
    input  logic [AW-1:0] thresh,
    input  logic          fall_pol,
    input  trig_mode_e    mode,
    input  logic [LW-1:0] width_lim,
    input  logic [DW-1:0] pat_val,
    input  logic [DW-1:0] pat_ign,
    output logic          hit
);
    localparam logic [LW-1:0] LIM_FLOOR = LW'(MINP);

    typedef struct packed {
        logic          seen;
        logic          prev_act;
        logic          in_pulse;
        logic [LW-1:0] plen;
    } det_t;

    det_t det_d, det_q;

    logic [DW-1:0] bit_ok;
    logic          pat_ok;
    logic          above, act, start, stop;
    logic [LW-1:0] lim;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign bit_ok[i] = pat_ign[i] | (dig_smp[i] ~^ pat_val[i]);
    end
    assign pat_ok = &bit_ok;

    always_comb begin
        above = (ana_smp >= thresh);
        act   = fall_pol ? ~above : above;
        start = det_q.seen & act & ~det_q.prev_act;
        stop  = det_q.seen & ~act & det_q.prev_act & det_q.in_pulse;
        lim   = (width_lim < LIM_FLOOR) ? LIM_FLOOR : width_lim;

        det_d = det_q;
        if (smp_valid) begin
            det_d.seen     = 1'b1;
            det_d.prev_act = act;
            if (start) begin
                det_d.in_pulse = 1'b1;
                det_d.plen     = LW'(1);
            end else if (det_q.in_pulse && act) begin
                if (det_q.plen != '1) det_d.plen = det_q.plen + LW'(1);
            end else if (stop) begin
                det_d.in_pulse = 1'b0;
            end
        end

        unique case (mode)
            MODE_LEVEL:   hit = smp_valid & start;
            MODE_SHORT:   hit = smp_valid & stop & (det_q.plen < lim);
            MODE_LONG:    hit = smp_valid & stop & (det_q.plen >= lim);
            default:      hit = smp_valid & pat_ok;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_pkg::*;
#(
    parameter int HW       = HOLD_W,
    parameter int POST_SMP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          hit,
    input  logic          force_trig,
    input  logic          arm,
    input  logic          adc_en,
    input  logic [HW-1:0] holdoff,
    output logic          trig_evt,
    output logic [3:0]    status,
    output logic          armed
);
    localparam int PW = $clog2(POST_SMP + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [PW-1:0] post;
        logic [HW-1:0] hold;
        logic          pend;
        logic          evt;
    } seq_t;

    seq_t s_d, s_q;
    logic rest;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        rest    = (s_q.st == ST_IDLE) || (s_q.st == ST_DONE);

        if (arm && rest) s_d.pend = 1'b1;
        if (smp_valid && s_q.hold != '0) s_d.hold = s_q.hold - HW'(1);

        unique case (s_q.st)
            ST_ARMED: begin
                if (force_trig || hit) begin
                    s_d.st   = ST_POST;
                    s_d.evt  = 1'b1;
                    s_d.post = PW'(POST_SMP);
                    s_d.hold = holdoff;
                end
            end
            ST_POST: begin
                if (smp_valid) begin
                    if (s_q.post == PW'(1)) s_d.st = ST_DONE;
                    else                    s_d.post = s_q.post - PW'(1);
                end
            end
            default: begin
                if ((s_q.pend || arm) && s_q.hold == '0) begin
                    s_d.st   = ST_ARMED;
                    s_d.pend = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, post: '0, hold: '0, pend: 1'b0, evt: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.st)
            ST_IDLE:  status = STAT_IDLE;
            ST_DONE:  status = STAT_READY;
            default:  status = adc_en ? STAT_ARM_ADC : STAT_ARM_NOADC;
        endcase
    end

    assign trig_evt = s_q.evt;
    assign armed    = (s_q.st == ST_ARMED);
endmodule

// File: rtl/scope_trig_unit.sv
module scope_trig_unit
    import trig_pkg::*;
#(
    parameter int POST_SMP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [ANA_W-1:0] ana_smp,
    input  logic [DIG_W-1:0] dig_smp,
    input  logic [7:0]       thr_lo,
    input  logic [7:0]       trig_cfg,
    input  logic [DIG_W-1:0] pat_val,
    input  logic [DIG_W-1:0] pat_ign,
    input  logic [7:0]       hold_lo,
    input  logic [7:0]       hold_hi,
    input  logic [LIM_W-1:0] width_lim,
    input  logic             arm,
    input  logic             adc_en,
    input  logic             force_trig,
    output logic             trig_evt,
    output logic [3:0]       status
);
    logic             det_hit;
    logic             seq_armed;
    logic [ANA_W-1:0] thresh;
    trig_mode_e       mode;

    assign thresh = {trig_cfg[1:0], thr_lo};
    assign mode   = trig_mode_e'(trig_cfg[6:5]);

    trig_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .ana_smp   (ana_smp),
        .dig_smp   (dig_smp),
        .thresh    (thresh),
        .fall_pol  (trig_cfg[2]),
        .mode      (mode),
        .width_lim (width_lim),
        .pat_val   (pat_val),
        .pat_ign   (pat_ign),
        .hit       (det_hit)
    );

    trig_seq #(.POST_SMP(POST_SMP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .hit        (det_hit),
        .force_trig (force_trig),
        .arm        (arm),
        .adc_en     (adc_en),
        .holdoff    ({hold_hi, hold_lo}),
        .trig_evt   (trig_evt),
        .status     (status),
        .armed      (seq_armed)
    );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_evt,
    input logic [3:0] status,
    input logic       force_trig,
    input logic       st_armed
);
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {4'h1, 4'h3, 4'h4, 4'h6}); // R7
    AST_ARMED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        st_armed |-> status inside {4'h3, 4'h4}); // R7
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |=> !trig_evt); // R8
    AST_EVT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_evt) |-> $past(st_armed)); // R8
    AST_FORCE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_armed && force_trig) |=> trig_evt); // R9
    AST_EVT_LEAVES_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |-> !st_armed); // R10
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'h6) |=> status inside {4'h6, 4'h3, 4'h4}); // R11
endmodule

bind scope_trig_unit trig_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_evt   (trig_evt),
    .status     (status),
    .force_trig (force_trig),
    .st_armed   (seq_armed)
);

// File: tb/scope_trig_unit_tb_top.sv
module scope_trig_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b1;
    logic [9:0] ana_smp = '0;
    logic [7:0] dig_smp = '0;
    logic [7:0] thr_lo = '0, trig_cfg = '0, pat_val = '0, pat_ign = '0;
    logic [7:0] hold_lo = '0, hold_hi = '0, width_lim = '0;
    logic       arm = 1'b0, adc_en = 1'b1, force_trig = 1'b0;
    logic       trig_evt;
    logic [3:0] status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scope_trig_unit dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ana_smp(ana_smp),
        .dig_smp(dig_smp), .thr_lo(thr_lo), .trig_cfg(trig_cfg), .pat_val(pat_val),
        .pat_ign(pat_ign), .hold_lo(hold_lo), .hold_hi(hold_hi), .width_lim(width_lim),
        .arm(arm), .adc_en(adc_en), .force_trig(force_trig),
        .trig_evt(trig_evt), .status(status)
    );

    // pattern vectors: [24:17] value, [16:9] ignore mask, [8:1] digital sample, [0] expected hit
    localparam logic [24:0] PAT_VEC [8] = '{
        {8'hA5, 8'h00, 8'hA5, 1'b1},
        {8'hA5, 8'h00, 8'hA4, 1'b0},
        {8'hA5, 8'h0F, 8'hAF, 1'b1},
        {8'hA5, 8'h0F, 8'hB5, 1'b0},
        {8'h00, 8'hFF, 8'h5A, 1'b1},
        {8'hFF, 8'h7F, 8'h80, 1'b1},
        {8'hFF, 8'h7F, 8'h7F, 1'b0},
        {8'h3C, 8'hC3, 8'h3C, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [9:0] a, input logic [7:0] d);
        ana_smp = a;
        dig_smp = d;
        @(posedge clk);
        #1;
        arm = 1'b0;
        force_trig = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b1;
        tick(10'd0, 8'h00);
        tick(10'd0, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic do_arm(input logic [9:0] a, input logic [7:0] d);
        arm = 1'b1;
        tick(a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // reset state
        do_reset();
        chk("R7 reset status", 16'(status), 16'h1);
        chk("R8 reset evt", 16'(trig_evt), 16'h0);

        // force while idle has no effect
        force_trig = 1'b1;
        tick(10'd0, 8'h00);
        chk("R9 force idle evt", 16'(trig_evt), 16'h0);
        chk("R9 force idle status", 16'(status), 16'h1);

        // armed status with converter off and on
        adc_en = 1'b0;
        do_arm(10'd0, 8'h00);
        chk("R7 armed noadc", 16'(status), 16'h3);
        adc_en = 1'b1;
        #1;
        chk("R7 armed adc", 16'(status), 16'h4);

        // pattern table
        for (int v = 0; v < 8; v++) begin
            do_reset();
            trig_cfg = 8'h60;
            pat_val = PAT_VEC[v][24:17];
            pat_ign = PAT_VEC[v][16:9];
            do_arm(10'd0, ~PAT_VEC[v][8:1]);
            tick(10'd0, PAT_VEC[v][8:1]);
            chk($sformatf("R6 pattern vec %0d", v), 16'(trig_evt), 16'(PAT_VEC[v][0]));
        end

        // level rising, threshold 0x180
        do_reset();
        thr_lo = 8'h80;
        trig_cfg = 8'h01;
        do_arm(10'd100, 8'h00);
        tick(10'd383, 8'h00);
        chk("R1 below threshold", 16'(trig_evt), 16'h0);
        tick(10'd384, 8'h00);
        chk("R2 rising edge at threshold", 16'(trig_evt), 16'h1);
        tick(10'd384, 8'h00);
        chk("R8 evt single cycle", 16'(trig_evt), 16'h0);
        tick(10'd384, 8'h00);
        tick(10'd384, 8'h00);
        chk("R10 post counting", 16'(status), 16'h4);
        tick(10'd384, 8'h00);
        chk("R10 ready after post", 16'(status), 16'h6);

        // level falling
        do_reset();
        trig_cfg = 8'h05;
        do_arm(10'd300, 8'h00);
        tick(10'd500, 8'h00);
        chk("R2 rise ignored in falling", 16'(trig_evt), 16'h0);
        tick(10'd383, 8'h00);
        chk("R2 falling edge", 16'(trig_evt), 16'h1);

        // short pulse mode, limit 6
        do_reset();
        trig_cfg = 8'h21;
        width_lim = 8'd6;
        do_arm(10'd100, 8'h00);
        for (int i = 0; i < 6; i++) tick(10'd400, 8'h00);
        tick(10'd100, 8'h00);
        chk("R4 six not short", 16'(trig_evt), 16'h0);
        for (int i = 0; i < 3; i++) tick(10'd400, 8'h00);
        chk("R4 no hit inside pulse", 16'(trig_evt), 16'h0);
        tick(10'd100, 8'h00);
        chk("R4 short pulse", 16'(trig_evt), 16'h1);

        // long pulse mode, limit 6
        do_reset();
        trig_cfg = 8'h41;
        do_arm(10'd100, 8'h00);
        for (int i = 0; i < 5; i++) tick(10'd400, 8'h00);
        tick(10'd100, 8'h00);
        chk("R5 five below limit", 16'(trig_evt), 16'h0);
        for (int i = 0; i < 6; i++) tick(10'd400, 8'h00);
        tick(10'd100, 8'h00);
        chk("R5 six at limit", 16'(trig_evt), 16'h1);

        // clamp: limit 2 acts as 4
        do_reset();
        width_lim = 8'd2;
        do_arm(10'd100, 8'h00);
        for (int i = 0; i < 3; i++) tick(10'd400, 8'h00);
        tick(10'd100, 8'h00);
        chk("R5 clamp three", 16'(trig_evt), 16'h0);
        for (int i = 0; i < 4; i++) tick(10'd400, 8'h00);
        tick(10'd100, 8'h00);
        chk("R5 clamp four", 16'(trig_evt), 16'h1);

        // kind selection
        do_reset();
        trig_cfg = 8'h61;
        pat_val = 8'h00;
        pat_ign = 8'h00;
        do_arm(10'd100, 8'hFF);
        tick(10'd500, 8'hFF);
        chk("R3 analog edge in pattern kind", 16'(trig_evt), 16'h0);
        do_reset();
        trig_cfg = 8'h01;
        do_arm(10'd100, 8'h00);
        tick(10'd100, 8'h00);
        chk("R3 pattern in level kind", 16'(trig_evt), 16'h0);

        // force when armed, coinciding with a pattern hit
        do_reset();
        trig_cfg = 8'h60;
        pat_val = 8'h5A;
        pat_ign = 8'h00;
        do_arm(10'd0, 8'h00);
        force_trig = 1'b1;
        tick(10'd0, 8'h5A);
        chk("R9 force with hit", 16'(trig_evt), 16'h1);
        tick(10'd0, 8'h5A);
        chk("R10 one event", 16'(trig_evt), 16'h0);
        tick(10'd0, 8'h5A);
        tick(10'd0, 8'h5A);
        chk("R10 single window", 16'(status), 16'h4);
        tick(10'd0, 8'h5A);
        chk("R10 ready once", 16'(status), 16'h6);

        // holdoff delays arming
        do_reset();
        hold_lo = 8'd10;
        hold_hi = 8'd0;
        do_arm(10'd0, 8'h00);
        force_trig = 1'b1;
        tick(10'd0, 8'h00);
        chk("R9 force armed", 16'(trig_evt), 16'h1);
        for (int k = 1; k <= 4; k++) tick(10'd0, 8'h00);
        chk("R10 ready before rearm", 16'(status), 16'h6);
        arm = 1'b1;
        tick(10'd0, 8'h00);
        chk("R11 arm held", 16'(status), 16'h6);
        for (int k = 6; k <= 10; k++) tick(10'd0, 8'h00);
        chk("R11 still holding", 16'(status), 16'h6);
        tick(10'd0, 8'h00);
        chk("R11 armed after holdoff", 16'(status), 16'h4);

        // invalid samples
        do_reset();
        hold_lo = 8'd0;
        do_arm(10'd0, 8'h00);
        smp_valid = 1'b0;
        tick(10'd0, 8'h5A);
        chk("R12 invalid no trigger", 16'(trig_evt), 16'h0);
        smp_valid = 1'b1;
        tick(10'd0, 8'h5A);
        chk("R12 valid triggers", 16'(trig_evt), 16'h1);
        smp_valid = 1'b0;
        for (int i = 0; i < 4; i++) tick(10'd0, 8'h00);
        chk("R12 post frozen", 16'(status), 16'h4);
        smp_valid = 1'b1;
        for (int i = 0; i < 4; i++) tick(10'd0, 8'h00);
        chk("R12 post resumes", 16'(status), 16'h6);

        finish_run();
    end
endmodule